// File: doc/BRIEF.md
# Narrow-to-Wide Shared RAM Bridge

This block lets an 8-bit processor bus reach a data RAM of 32-bit words that a wide compute engine also uses. The processor addresses single bytes. The bridge turns these byte accesses into whole-word RAM transfers through two holding registers, one for reads and one for writes. A byte read of lane 0 fetches the whole word. A byte write of the top lane stores the whole word. Every other byte access is served from, or staged into, a holding register and does not touch the RAM.

Each processor access is stretched by a number of wait cycles. A 2-bit speed setting selects that number, so that a fast processor clock gets more waits than a slow one. The compute engine has its own single-cycle port with absolute priority. A processor access that needs the RAM in a cycle where the engine uses it waits one more cycle for each such cycle.

The processor places a one-cycle request when `cpu_busy` is low. It then sees a one-cycle `cpu_done` pulse, which carries the read byte on `cpu_rdata`.

Top module: `nwb_bridge`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done`, `cpu_rdata` and `ce_rdata` are 0, and both holding registers are 0. A read of lane 1, 2 or 3 before any lane-0 read therefore returns 0.
- R2: A request accepted at a clock edge produces a single-cycle `cpu_done` pulse exactly W+1 edges later when no conflict occurs. W comes from `cfg_speed` sampled at acceptance: 2'b00 gives 0 (test setting), 2'b01 gives 1 (slowest clock), 2'b10 gives 2, and 2'b11 gives 5 (fastest clock). `cpu_busy` stays high from acceptance until the edge that raises `cpu_done`.
- R3: A processor read of lane 0 loads the full addressed word into the read holding register and returns bits 7:0.
- R4: A processor read of lane k (1..3) returns bits 8k+7:8k of the read holding register without accessing the RAM. Engine writes made after the last lane-0 read are therefore not seen.
- R5: A processor write to lane 0, 1 or 2 only stages the byte in the write holding register. The RAM word is unchanged.
- R6: A processor write to lane 3 writes the word addressed by that lane-3 access. The word is `{cpu_wdata, staged lane 2, staged lane 1, staged lane 0}`.
- R7: A processor access needs the RAM only when it is a lane-0 read or a lane-3 write. When such an access is ready to finish in a cycle with `ce_en` high, it is held for that cycle and its latency grows by one per such cycle. Accesses that do not need the RAM are not delayed by `ce_en`. The RAM never takes a processor write in a cycle with `ce_en` high.
- R8: When `ce_en` and `ce_we` are high, the engine writes `ce_wdata` to `ce_addr`. When `ce_en` is high and `ce_we` is low, the word at `ce_addr` appears on `ce_rdata` after the next edge.
- R9: `cpu_req` is ignored while `cpu_busy` is high. It does not change the access in flight, the holding registers, or the number of `cpu_done` pulses.
- R10: `cpu_addr[1:0]` selects the byte lane and `cpu_addr[8:2]` selects the word. The lanes are little-endian, with lane 0 on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_speed | input | 2 | Processor clock setting that selects the wait count |
| cpu_req | input | 1 | One-cycle access request, taken when not busy |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 9 | Byte address: word in [8:2], lane in [1:0] |
| cpu_wdata | input | 8 | Write byte |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` |
| ce_en | input | 1 | Engine access strobe (priority) |
| ce_we | input | 1 | Engine write enable |
| ce_addr | input | 7 | Engine word address |
| ce_wdata | input | 32 | Engine write word |
| ce_rdata | output | 32 | Engine read word, one cycle after the strobe |

## Verification
The bench builds the bridge with its default parameters: 128 words, 32-bit words split into four 8-bit lanes, and wait counts of 1, 2 and 5. The zero-wait test setting exposes the shortest turnaround between a completion and the next acceptance. The five-wait setting leaves a window long enough to inject a request during a busy access. Engine strobes held across the final cycle of a lane-0 read measure the priority stretch. Each lane position is walked, so byte ordering, staleness of the read holding register and deferred commits are all seen through the engine port.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  typedef enum logic [1:0] {
    SPD_TEST = 2'b00,
    SPD_SLOW = 2'b01,
    SPD_MID  = 2'b10,
    SPD_FAST = 2'b11
  } spd_e;

  // Wait cycles for a speed setting.
  function automatic int unsigned wait_for(input logic [1:0] sel,
                                           input int unsigned w_slow,
                                           input int unsigned w_mid,
                                           input int unsigned w_fast);
    case (spd_e'(sel))
      SPD_SLOW: return w_slow;
      SPD_MID:  return w_mid;
      SPD_FAST: return w_fast;
      default:  return 0;
    endcase
  endfunction

  // Largest of three wait counts, used to size the counter.
  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True when an access has to touch the wide RAM.
  function automatic logic needs_ram(input logic we,
                                     input int unsigned lane,
                                     input int unsigned lanes);
    return we ? (lane == lanes - 1) : (lane == 0);
  endfunction

endpackage

// File: rtl/nwb_waitgen.sv
module nwb_waitgen #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] wait_n,
  input  logic          stall,
  output logic          busy,
  output logic          fire
);

  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign fire     = busy && cnt_zero && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= wait_n;
    end else if (busy) begin
      if (!cnt_zero)   cnt_q <= cnt_q - 1'b1;
      else if (!stall) busy  <= 1'b0;
    end
  end

  // Shadow window for the wait check: busy cycles elapsed since start.
  localparam int EW = CW + 4;
  logic [EW-1:0] elapsed_q;
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      wait_q    <= '0;
    end else if (start && !busy) begin
      elapsed_q <= '0;
      wait_q    <= wait_n;
    end else if (busy && (elapsed_q != '1)) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  AST_WAIT_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (EW'(wait_q) <= elapsed_q)); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_zero && stall) |=> busy); // R7

endmodule

// File: rtl/nwb_lanes.sv
module nwb_lanes #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = WORD_W / LANE_W,
  parameter int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              we,
  input  logic [LW-1:0]     lane,
  input  logic [LANE_W-1:0] wdata,
  input  logic [WORD_W-1:0] ram_word,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word,
  output logic [LANE_W-1:0] rdata
);

  localparam logic [LW-1:0] LAST = LW'(LANES - 1);

  logic [WORD_W-1:0] wr_hold_q;
  logic [WORD_W-1:0] rd_hold_q;
  logic              is_last;
  logic              is_first;

  assign is_last  = (lane == LAST);
  assign is_first = (lane == '0);
  assign commit   = fire && we && is_last;

  // Top lane comes straight from the bus; lower lanes from staging.
  for (genvar g = 0; g < LANES; g++) begin : g_cw
    if (g == LANES - 1) begin : g_top
      assign commit_word[g*LANE_W +: LANE_W] = wdata;
    end else begin : g_low
      assign commit_word[g*LANE_W +: LANE_W] = wr_hold_q[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_hold_q <= '0;
      rd_hold_q <= '0;
      rdata     <= '0;
    end else if (fire) begin
      if (we) begin
        if (!is_last) wr_hold_q[lane*LANE_W +: LANE_W] <= wdata;
      end else if (is_first) begin
        rd_hold_q <= ram_word;
        rdata     <= ram_word[LANE_W-1:0];
      end else begin
        rdata <= rd_hold_q[lane*LANE_W +: LANE_W];
      end
    end
  end

  AST_READ_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !we) |=> $stable(wr_hold_q)); // R5
  AST_WRITE_KEEPS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && we) |=> $stable(rd_hold_q)); // R4

endmodule

// File: rtl/nwb_ram.sv
module nwb_ram #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_en,
  input  logic              ce_we,
  input  logic [AW-1:0]     ce_addr,
  input  logic [WORD_W-1:0] ce_wdata,
  output logic [WORD_W-1:0] ce_rdata,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rword
);

  logic [WORD_W-1:0] mem [DEPTH];

  assign cpu_rword = mem[cpu_addr];

  // Engine has the port whenever it strobes.
  always_ff @(posedge clk) begin
    if (ce_en && ce_we)  mem[ce_addr]  <= ce_wdata;
    else if (cpu_wr)     mem[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ce_rdata <= '0;
    else if (ce_en && !ce_we)   ce_rdata <= mem[ce_addr];
  end

  AST_ENGINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !ce_en); // R7

endmodule

// File: rtl/nwb_bridge.sv
module nwb_bridge #(
  parameter int DEPTH     = 128,
  parameter int WORD_W    = 32,
  parameter int LANE_W    = 8,
  parameter int WAIT_SLOW = 1,
  parameter int WAIT_MID  = 2,
  parameter int WAIT_FAST = 5
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [1:0]                                  cfg_speed,
  input  logic                                        cpu_req,
  input  logic                                        cpu_we,
  input  logic [$clog2(DEPTH)+$clog2(WORD_W/LANE_W)-1:0] cpu_addr,
  input  logic [LANE_W-1:0]                           cpu_wdata,
  output logic                                        cpu_busy,
  output logic                                        cpu_done,
  output logic [LANE_W-1:0]                           cpu_rdata,
  input  logic                                        ce_en,
  input  logic                                        ce_we,
  input  logic [$clog2(DEPTH)-1:0]                    ce_addr,
  input  logic [WORD_W-1:0]                           ce_wdata,
  output logic [WORD_W-1:0]                           ce_rdata
);

  import nwb_pkg::*;

  localparam int LANES = WORD_W / LANE_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(LANES);
  localparam int WMAX  = int'(max3(WAIT_SLOW, WAIT_MID, WAIT_FAST));
  localparam int CW    = (WMAX < 1) ? 1 : $clog2(WMAX + 1);

  // Request capture
  logic              accept;
  logic              req_we_q;
  logic [AW-1:0]     req_word_q;
  logic [LW-1:0]     req_lane_q;
  logic [LANE_W-1:0] req_data_q;
  logic [CW-1:0]     wait_sel;

  // Named internal events
  logic              need_ram;
  logic              stall;
  logic              fire;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] ram_word;

  assign accept   = cpu_req && !cpu_busy;
  assign wait_sel = CW'(wait_for(cfg_speed, WAIT_SLOW, WAIT_MID, WAIT_FAST));
  assign need_ram = needs_ram(req_we_q, int'(req_lane_q), LANES);
  assign stall    = need_ram && ce_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_we_q   <= 1'b0;
      req_word_q <= '0;
      req_lane_q <= '0;
      req_data_q <= '0;
    end else if (accept) begin
      req_we_q   <= cpu_we;
      req_word_q <= cpu_addr[LW +: AW];
      req_lane_q <= cpu_addr[LW-1:0];
      req_data_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_done <= 1'b0;
    else        cpu_done <= fire;
  end

  nwb_waitgen #(.CW(CW)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .wait_n (wait_sel),
    .stall  (stall),
    .busy   (cpu_busy),
    .fire   (fire)
  );

  nwb_lanes #(
    .WORD_W (WORD_W),
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .LW     (LW)
  ) u_lanes (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .we          (req_we_q),
    .lane        (req_lane_q),
    .wdata       (req_data_q),
    .ram_word    (ram_word),
    .commit      (commit),
    .commit_word (commit_word),
    .rdata       (cpu_rdata)
  );

  nwb_ram #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W),
    .AW     (AW)
  ) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_en     (ce_en),
    .ce_we     (ce_we),
    .ce_addr   (ce_addr),
    .ce_wdata  (ce_wdata),
    .ce_rdata  (ce_rdata),
    .cpu_addr  (req_word_q),
    .cpu_wr    (commit),
    .cpu_wdata (commit_word),
    .cpu_rword (ram_word)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R2
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_busy) |-> cpu_done); // R2
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && cpu_req) |=> ($stable(req_word_q) && $stable(req_lane_q))); // R9

endmodule

// File: tb/tb_nwb_bridge.sv
module tb_nwb_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_speed = 2'b00;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [8:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_busy;
  logic        cpu_done;
  logic [7:0]  cpu_rdata;
  logic        ce_en = 1'b0;
  logic        ce_we = 1'b0;
  logic [6:0]  ce_addr = '0;
  logic [31:0] ce_wdata = '0;
  logic [31:0] ce_rdata;

  always #2 clk = ~clk;  // 250 MHz

  nwb_bridge dut (
    .clk(clk), .rst_n(rst_n), .cfg_speed(cfg_speed),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .ce_en(ce_en), .ce_we(ce_we),
    .ce_addr(ce_addr), .ce_wdata(ce_wdata), .ce_rdata(ce_rdata)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit         rd;
    logic [7:0] data;
    int         lat;
    int         start;
    string      tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Wait count from the speed encoding, restated from R2.
  function automatic int waits(input logic [1:0] s);
    case (s)
      2'b01:   return 1;
      2'b10:   return 2;
      2'b11:   return 5;
      default: return 0;
    endcase
  endfunction

  // Monitor: pops expectations as completions appear.
  always @(negedge clk) begin
    if (rst_n && cpu_done) begin
      if (sb.size() == 0) begin
        chk("R9", "completion with no request pending", 1, 0);
      end else begin
        mon_e = sb.pop_front();
        chk(mon_e.tag, "latency", cyc - mon_e.start, mon_e.lat);
        if (mon_e.rd) chk(mon_e.tag, "read byte", cpu_rdata, mon_e.data);
      end
    end
  end

  // Driver: one processor access; optional intrusion while busy.
  task automatic cpu_op(input bit we, input int word, input int lane,
                        input logic [7:0] wd, input logic [7:0] exp_rd,
                        input int ext, input bit intrude, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_addr  = {7'(word), 2'(lane)};
    cpu_wdata = wd;
    e.rd = !we; e.data = exp_rd; e.lat = waits(cfg_speed) + 1 + ext;
    e.start = cyc + 1; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cpu_req = 1'b0;
    if (intrude) begin
      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_we   = 1'b0;
      cpu_addr = {7'd20, 2'd0};
      @(negedge clk);
      cpu_req = 1'b0;
    end
    while (!cpu_done) @(negedge clk);
  endtask

  task automatic ce_write(input int word, input logic [31:0] d);
    @(negedge clk);
    ce_en = 1'b1; ce_we = 1'b1; ce_addr = 7'(word); ce_wdata = d;
    @(negedge clk);
    ce_en = 1'b0; ce_we = 1'b0;
  endtask

  task automatic ce_read(input int word, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ce_en = 1'b1; ce_we = 1'b0; ce_addr = 7'(word);
    @(negedge clk);
    ce_en = 1'b0;
    chk(tag, "engine read word", ce_rdata, exp);
  endtask

  task automatic ce_hold(input int word, input int n);
    @(negedge clk);
    ce_en = 1'b1; ce_we = 1'b0; ce_addr = 7'(word);
    repeat (n) @(negedge clk);
    ce_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "busy after reset", cpu_busy, 0);
    chk("R1", "done after reset", cpu_done, 0);
    chk("R1", "rdata after reset", cpu_rdata, 0);
    chk("R1", "engine rdata after reset", ce_rdata, 0);
    rst_n = 1'b1;

    // R1 / R4: lane 1 before any fetch comes from the cleared holding reg
    cfg_speed = 2'b00;
    cpu_op(0, 5, 1, 8'h00, 8'h00, 0, 0, "R1");

    // R8: engine write then read
    ce_write(10, 32'hA1B2C3D4);
    ce_read(10, 32'hA1B2C3D4, "R8");

    // R3 / R10 / R2: lane walk at one wait
    cfg_speed = 2'b01;
    cpu_op(0, 10, 0, 8'h00, 8'hD4, 0, 0, "R3");
    cpu_op(0, 10, 1, 8'h00, 8'hC3, 0, 0, "R10");
    cpu_op(0, 10, 2, 8'h00, 8'hB2, 0, 0, "R10");
    cpu_op(0, 10, 3, 8'h00, 8'hA1, 0, 0, "R4");

    // R4: engine update not visible until next lane-0 read
    ce_write(10, 32'h11223344);
    cpu_op(0, 10, 2, 8'h00, 8'hB2, 0, 0, "R4");
    cpu_op(0, 10, 0, 8'h00, 8'h44, 0, 0, "R3");

    // R5 / R6: staged writes at two waits
    cfg_speed = 2'b10;
    ce_write(20, 32'hDEADBEEF);
    cpu_op(1, 20, 0, 8'h55, 8'h00, 0, 0, "R5");
    cpu_op(1, 20, 1, 8'h66, 8'h00, 0, 0, "R5");
    cpu_op(1, 20, 2, 8'h77, 8'h00, 0, 0, "R5");
    ce_read(20, 32'hDEADBEEF, "R5");
    cpu_op(1, 20, 3, 8'h88, 8'h00, 0, 0, "R6");
    ce_read(20, 32'h88776655, "R6");

    // R6: commit goes to the word named by the lane-3 access, at five waits
    cfg_speed = 2'b11;
    ce_write(30, 32'hCAFEF00D);
    ce_write(31, 32'h00000000);
    cpu_op(1, 30, 0, 8'h01, 8'h00, 0, 0, "R6");
    cpu_op(1, 30, 1, 8'h02, 8'h00, 0, 0, "R6");
    cpu_op(1, 30, 2, 8'h03, 8'h00, 0, 0, "R6");
    cpu_op(1, 31, 3, 8'h04, 8'h00, 0, 0, "R6");
    ce_read(31, 32'h04030201, "R6");
    ce_read(30, 32'hCAFEF00D, "R6");

    // R7: engine strobes over the final cycle of a lane-0 read add two cycles
    cfg_speed = 2'b10;
    fork
      ce_hold(31, 5);
      cpu_op(0, 20, 0, 8'h00, 8'h55, 2, 0, "R7");
    join
    chk("R7", "engine read during conflict", ce_rdata, 32'h04030201);
    // R7: lane-only read is not delayed by engine strobes
    fork
      ce_hold(31, 5);
      cpu_op(0, 20, 1, 8'h00, 8'h66, 0, 0, "R7");
    join

    // R9: request while busy is dropped
    cfg_speed = 2'b11;
    cpu_op(0, 10, 0, 8'h00, 8'h44, 0, 1, "R9");
    repeat (3) @(negedge clk);
    chk("R9", "no extra completion pending", sb.size(), 0);
    cpu_op(0, 10, 1, 8'h00, 8'h33, 0, 0, "R9");

    // R2: back-to-back zero-wait accesses
    cfg_speed = 2'b00;
    cpu_op(0, 10, 3, 8'h00, 8'h11, 0, 0, "R2");
    cpu_op(0, 10, 2, 8'h00, 8'h22, 0, 0, "R2");

    repeat (4) @(negedge clk);
    chk("R2", "busy idle at end", cpu_busy, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule